// File: doc/BRIEF.md
# Open-Page Policy Controller

This block sits beside an SDRAM command scheduler and decides two things: when a bank whose row has sat unused for a while should be closed, and when a run of page-hit services has gone on long enough that a waiting page-miss request must be served. It does not issue commands itself. It watches activate, read/write and precharge events per bank, and the grant stream of the scheduler. It returns a per-bank close request and a single priority-override flag.

Two small codes configure it. A 3-bit idle code selects how many idle cycles an open bank may sit before its close request rises, or turns automatic closing off. A 2-bit limit code selects how many page-hit services in a row are allowed while a page-miss request is waiting. Both codes map to coarse, non-linear steps. The scheduler is expected to act on `close_req` by issuing a precharge, and on `force_miss` by granting the waiting page-miss request next.

All pins are plain control and status signals sampled on the rising clock edge. The block has no data path and no valid/ready handshake. Events are single-cycle pulses and apply in the cycle they are seen.

Top module: `open_page_policy`

## Requirements
- R1: Idle code to idle-cycle threshold T: 000=0, 001=8, 010=12, 011=16, 100=24, 101=32, 110=48. After the last activate or read/write of an open bank at clock edge k, with no further event on that bank, `close_req` for that bank is low after edge k+T and high after edge k+T+1.
- R2: Idle code 111 disables automatic closing. While it is applied, no close request rises, and any pending close request drops after the next edge.
- R3: After reset, every bank is closed, every `close_req` bit is 0 and `force_miss` is 0.
- R4: With idle code 000, the close request of an open bank rises after the first clock edge following its last access.
- R5: An activate or read/write pulse on a bank opens it, restarts its idle count from zero and clears its pending close request. Activate and read/write take precedence over a precharge on the same bank in the same cycle.
- R6: A precharge pulse on a bank closes it and clears its close request. A closed bank never raises a close request, however long it stays idle.
- R7: Limit code to streak limit L: 00=1, 01=4, 10=8, 11=16. With `miss_waiting` held high, `force_miss` rises after the edge that captures the L-th consecutive `hit_grant`, and not before.
- R8: The hit streak restarts from zero on any edge where `miss_waiting` is low, or where `miss_grant` is high.
- R9: Once raised, `force_miss` stays high, including while no hits arrive, until an edge with `miss_grant` high. After that edge it is low.
- R10: The banks are independent. Events on one bank do not change the close request of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_code | input | 3 | Idle-close interval code (111 = off) |
| limit_code | input | 2 | Page-hit streak limit code |
| bank_act | input | NUM_BANKS | Per-bank activate pulse |
| bank_rw | input | NUM_BANKS | Per-bank read or write pulse |
| bank_pre | input | NUM_BANKS | Per-bank precharge pulse |
| miss_waiting | input | 1 | A page-miss request is queued |
| hit_grant | input | 1 | A page-hit request was served this cycle |
| miss_grant | input | 1 | A page-miss request was served this cycle |
| close_req | output | NUM_BANKS | Per-bank request to precharge an idle open bank |
| force_miss | output | 1 | Override: serve the waiting page-miss request next |

## Verification
The bench builds the block with its default of four banks. These default widths hold the largest idle threshold (48) and the largest streak limit (16), so every idle code and every limit code can be swept to its exact edge-of-threshold cycle. With four banks, a bank can be kept busy or closed while a neighbour times out, which exposes any cross-bank coupling. The streak tests also break a run with a cycle of no waiting request and with a page-miss grant, so the reset and stickiness rules are observed directly.

// File: rtl/opp_pkg.sv
package opp_pkg;

  localparam int IDLE_CODE_W  = 3;
  localparam int LIMIT_CODE_W = 2;
  localparam int IDLE_MAX     = 48;
  localparam int STREAK_MAX   = 16;
  localparam int IDLE_CNT_W   = $clog2(IDLE_MAX + 2);
  localparam int STREAK_W     = $clog2(STREAK_MAX + 1);

  localparam logic [IDLE_CODE_W-1:0] IDLE_OFF = 3'b111;

  // idle code -> number of idle cycles tolerated
  function automatic logic [IDLE_CNT_W-1:0] idle_cycles(input logic [IDLE_CODE_W-1:0] code);
    logic [IDLE_CNT_W-1:0] v;
    case (code)
      3'b000:  v = IDLE_CNT_W'(0);
      3'b001:  v = IDLE_CNT_W'(8);
      3'b010:  v = IDLE_CNT_W'(12);
      3'b011:  v = IDLE_CNT_W'(16);
      3'b100:  v = IDLE_CNT_W'(24);
      3'b101:  v = IDLE_CNT_W'(32);
      3'b110:  v = IDLE_CNT_W'(48);
      default: v = IDLE_CNT_W'(0);
    endcase
    return v;
  endfunction

  // limit code -> page-hit services allowed while a miss waits
  function automatic logic [STREAK_W-1:0] streak_cap(input logic [LIMIT_CODE_W-1:0] code);
    logic [STREAK_W-1:0] v;
    case (code)
      2'b00:   v = STREAK_W'(1);
      2'b01:   v = STREAK_W'(4);
      2'b10:   v = STREAK_W'(8);
      default: v = STREAK_W'(16);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/opp_code_decode.sv
module opp_code_decode
  import opp_pkg::*;
(
  input  logic [IDLE_CODE_W-1:0]  idle_code,
  input  logic [LIMIT_CODE_W-1:0] limit_code,
  output logic                    idle_en,
  output logic [IDLE_CNT_W-1:0]   idle_thr,
  output logic [STREAK_W-1:0]     hit_cap
);

  always_comb begin
    idle_en  = (idle_code != IDLE_OFF);
    idle_thr = idle_cycles(idle_code);
    hit_cap  = streak_cap(limit_code);
  end

  // R1: the largest enabled threshold stays within the counter range
  always_comb begin
    if (idle_en) assert (int'(idle_thr) <= IDLE_MAX)
      else $error("a_r1_thr_range");
  end

endmodule

// File: rtl/opp_bank_timer.sv
module opp_bank_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] thr,
  input  logic             act,
  input  logic             rw,
  input  logic             pre,
  output logic             is_open,
  output logic             close_req
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic             open_q;
  logic [CNT_W-1:0] idle_q;
  logic             pend_q;
  logic             touch;

  assign touch = act | rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idle_q <= '0;
      pend_q <= 1'b0;
    end else if (touch) begin
      open_q <= 1'b1;
      idle_q <= '0;
      pend_q <= 1'b0;
    end else if (pre) begin
      open_q <= 1'b0;
      idle_q <= '0;
      pend_q <= 1'b0;
    end else if (open_q) begin
      if (idle_q != CNT_TOP) idle_q <= idle_q + 1'b1;
      pend_q <= en & (pend_q | (idle_q >= thr));
    end
  end

  assign is_open   = open_q;
  assign close_req = pend_q;

  a_r6_only_open: assert property (@(posedge clk) disable iff (!rst_n)
    close_req |-> is_open);

  a_r5_touch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (is_open && !close_req));

  a_r6_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (pre && !touch) |=> (!is_open && !close_req));

  a_r2_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !close_req);

endmodule

// File: rtl/opp_streak_guard.sv
module opp_streak_guard #(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] cap,
  input  logic          miss_waiting,
  input  logic          hit_grant,
  input  logic          miss_grant,
  output logic          force_miss
);

  logic [SW-1:0] streak_q;
  logic          force_q;
  logic [SW:0]   streak_inc;

  assign streak_inc = {1'b0, streak_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak_q <= '0;
      force_q  <= 1'b0;
    end else if (miss_grant) begin
      streak_q <= '0;
      force_q  <= 1'b0;
    end else if (!miss_waiting) begin
      streak_q <= '0;
    end else if (hit_grant) begin
      if (streak_q < cap) streak_q <= streak_inc[SW-1:0];
      if (streak_inc >= {1'b0, cap}) force_q <= 1'b1;
    end
  end

  assign force_miss = force_q;

  a_r7_rise_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_miss && !(hit_grant && miss_waiting)) |=> !force_miss);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (force_miss && !miss_grant) |=> force_miss);

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    miss_grant |=> !force_miss);

  a_r8_idle_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_waiting |=> (streak_q == '0));

endmodule

// File: rtl/open_page_policy.sv
module open_page_policy
  import opp_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDLE_CODE_W-1:0]  idle_code,
  input  logic [LIMIT_CODE_W-1:0] limit_code,
  input  logic [NUM_BANKS-1:0]    bank_act,
  input  logic [NUM_BANKS-1:0]    bank_rw,
  input  logic [NUM_BANKS-1:0]    bank_pre,
  input  logic                    miss_waiting,
  input  logic                    hit_grant,
  input  logic                    miss_grant,
  output logic [NUM_BANKS-1:0]    close_req,
  output logic                    force_miss
);

  logic                  idle_en;
  logic [IDLE_CNT_W-1:0] idle_thr;
  logic [STREAK_W-1:0]   hit_cap;
  logic [NUM_BANKS-1:0]  open_vec;

  opp_code_decode u_dec (
    .idle_code  (idle_code),
    .limit_code (limit_code),
    .idle_en    (idle_en),
    .idle_thr   (idle_thr),
    .hit_cap    (hit_cap)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    opp_bank_timer #(.CNT_W(IDLE_CNT_W)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (idle_en),
      .thr       (idle_thr),
      .act       (bank_act[b]),
      .rw        (bank_rw[b]),
      .pre       (bank_pre[b]),
      .is_open   (open_vec[b]),
      .close_req (close_req[b])
    );
  end

  opp_streak_guard #(.SW(STREAK_W)) u_streak (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap          (hit_cap),
    .miss_waiting (miss_waiting),
    .hit_grant    (hit_grant),
    .miss_grant   (miss_grant),
    .force_miss   (force_miss)
  );

  a_r6_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (close_req & ~open_vec) == '0);

endmodule

// File: tb/sim_open_page_policy.sv
`timescale 1ns/1ps
module sim_open_page_policy;

  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    idle_code = 3'b001;
  logic [1:0]    limit_code = 2'b10;
  logic [NB-1:0] bank_act = '0;
  logic [NB-1:0] bank_rw = '0;
  logic [NB-1:0] bank_pre = '0;
  logic          miss_waiting = 1'b0;
  logic          hit_grant = 1'b0;
  logic          miss_grant = 1'b0;
  logic [NB-1:0] close_req;
  logic          force_miss;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  open_page_policy #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .idle_code(idle_code), .limit_code(limit_code),
    .bank_act(bank_act), .bank_rw(bank_rw), .bank_pre(bank_pre),
    .miss_waiting(miss_waiting), .hit_grant(hit_grant), .miss_grant(miss_grant),
    .close_req(close_req), .force_miss(force_miss)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int idle_t(input logic [2:0] c);
    case (c)
      3'd0: return 0;  3'd1: return 8;  3'd2: return 12; 3'd3: return 16;
      3'd4: return 24; 3'd5: return 32; default: return 48;
    endcase
  endfunction

  function automatic int lim_n(input logic [1:0] c);
    case (c)
      2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 16;
    endcase
  endfunction

  // R3
  task automatic t_reset;
    chk("R3 close_req", 32'(close_req), 0);
    chk("R3 force_miss", 32'(force_miss), 0);
    tick(60);
    chk("R3/R6 closed banks stay quiet", 32'(close_req), 0);
  endtask

  // R1 R4 R6 per idle code on bank b
  task automatic t_idle(input logic [2:0] code, input int b);
    int t = idle_t(code);
    idle_code = code;
    bank_act[b] = 1'b1;
    tick(1);
    bank_act[b] = 1'b0;
    tick(t);
    chk((code == 0) ? "R4 before first edge" : "R1 low at T", 32'(close_req[b]), 0);
    tick(1);
    chk((code == 0) ? "R4 high after first idle edge" : "R1 high at T+1", 32'(close_req[b]), 1);
    chk("R10 other banks quiet", 32'(close_req & ~(NB'(1) << b)), 0);
    bank_pre[b] = 1'b1;
    tick(1);
    bank_pre[b] = 1'b0;
    chk("R6 precharge clears", 32'(close_req[b]), 0);
    tick(t + 4);
    chk("R6 closed bank quiet", 32'(close_req[b]), 0);
  endtask

  // R5: a read/write reloads the count and clears a pending request
  task automatic t_reload;
    idle_code = 3'b001;
    bank_act[1] = 1'b1; tick(1); bank_act[1] = 1'b0;
    tick(6);
    bank_rw[1] = 1'b1; tick(1); bank_rw[1] = 1'b0;
    tick(8);
    chk("R5 reload delays close", 32'(close_req[1]), 0);
    tick(1);
    chk("R5 close after reload", 32'(close_req[1]), 1);
    bank_rw[1] = 1'b1; bank_pre[1] = 1'b1; tick(1);
    bank_rw[1] = 1'b0; bank_pre[1] = 1'b0;
    chk("R5 access clears pending, beats precharge", 32'(close_req[1]), 0);
    tick(9);
    chk("R5 bank still open after rw+pre", 32'(close_req[1]), 1);
    bank_pre[1] = 1'b1; tick(1); bank_pre[1] = 1'b0;
  endtask

  // R2
  task automatic t_disable;
    idle_code = 3'b000;
    bank_act[2] = 1'b1; tick(1); bank_act[2] = 1'b0;
    tick(1);
    chk("R2 setup pending", 32'(close_req[2]), 1);
    idle_code = 3'b111;
    tick(1);
    chk("R2 off drops pending", 32'(close_req[2]), 0);
    tick(70);
    chk("R2 off never closes", 32'(close_req[2]), 0);
    idle_code = 3'b000;
    tick(1);
    chk("R2 re-enable closes", 32'(close_req[2]), 1);
    bank_pre[2] = 1'b1; tick(1); bank_pre[2] = 1'b0;
  endtask

  // R10: busy bank 0 beside idle bank 3
  task automatic t_indep;
    idle_code = 3'b001;
    bank_act[0] = 1'b1; bank_act[3] = 1'b1; tick(1);
    bank_act = '0;
    for (int i = 0; i < 9; i++) begin
      bank_rw[0] = 1'b1; tick(1);
    end
    bank_rw[0] = 1'b0;
    chk("R10 idle bank closes", 32'(close_req[3]), 1);
    chk("R10 busy bank not closed", 32'(close_req[0]), 0);
    bank_pre = 4'b1001; tick(1); bank_pre = '0;
    chk("R10 both cleared", 32'(close_req), 0);
  endtask

  // R7 R9 per limit code
  task automatic t_streak(input logic [1:0] code);
    int l = lim_n(code);
    limit_code = code;
    miss_waiting = 1'b1;
    hit_grant = 1'b1;
    for (int i = 1; i <= l; i++) begin
      tick(1);
      if (i < l) chk("R7 no force before limit", 32'(force_miss), 0);
      else       chk("R7 force at limit", 32'(force_miss), 1);
    end
    hit_grant = 1'b0;
    miss_waiting = 1'b0;
    tick(5);
    chk("R9 force sticky", 32'(force_miss), 1);
    miss_waiting = 1'b1; miss_grant = 1'b1;
    tick(1);
    miss_grant = 1'b0; miss_waiting = 1'b0;
    chk("R9 released by miss grant", 32'(force_miss), 0);
  endtask

  // R8
  task automatic t_streak_reset;
    limit_code = 2'b01;
    miss_waiting = 1'b1; hit_grant = 1'b1; tick(3);
    miss_waiting = 1'b0; tick(1);
    miss_waiting = 1'b1; tick(3);
    chk("R8 gap in waiting restarts streak", 32'(force_miss), 0);
    hit_grant = 1'b0; miss_grant = 1'b1; tick(1); miss_grant = 1'b0;
    hit_grant = 1'b1; tick(3);
    chk("R8 miss grant restarts streak", 32'(force_miss), 0);
    tick(1);
    chk("R8 fourth hit reaches limit", 32'(force_miss), 1);
    hit_grant = 1'b0; miss_grant = 1'b1; tick(1);
    miss_grant = 1'b0; miss_waiting = 1'b0;
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    for (int c = 0; c < 7; c++) t_idle(3'(c), c % NB);
    t_reload();
    t_disable();
    t_indep();
    for (int c = 0; c < 4; c++) t_streak(2'(c));
    t_streak_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule